// File: doc/BRIEF.md
# Multi-segment pixel repeater buffer

This block is the output buffer stage of a display pipe. It accepts one pixel per clock over a valid/ready handshake, together with a marker on the last pixel of each line. Each accepted pixel is emitted a programmable number of times. The repeated stream is then cut into horizontal segments for a panel link that carries a line as several parallel segments.

Each segment has its own output lane with a valid, a first-beat marker, a last-beat marker and a segment number. Every lane carries the same pixel value. A beat near a segment boundary can be valid on two neighbouring lanes at once, because a segment can carry a few overlap pixels taken from the start of the next segment. One common ready input accepts all lanes of a beat together.

The configuration is captured when the first pixel of a line is accepted. It holds the active width, the segmentation mode, the overlap count and the repetition count. A sticky error output reports a configuration that cannot be honoured.

Top module: `mso_pix_seg_buf`

## Requirements
- R1: Each accepted pixel appears on the output for cfg_rep_i + 1 consecutive accepted beats, in input order. cfg_rep_i is 4 bits, so a value of 0 gives exactly one beat per pixel.
- R2: in_ready_o is low while the held pixel still has repetitions pending, and low while a beat is stalled by out_ready_i. No input pixel is lost or duplicated under back-pressure. With out_ready_i held high, consecutive pixels are accepted exactly cfg_rep_i + 1 cycles apart.
- R3: The segmentation mode field cfg_mode_i selects how many lanes are used:
  - 0 uses lane 0 only.
  - 1 uses lanes 0 and 1.
  - 2 uses lanes 0 to 3.

  The segment width W is cfg_width_i divided by the lane count. Positions count repeated output beats from 0 at line start. Beat p is primarily on lane min(p div W, count - 1).
- R4: Mode 3 (left half) and mode 4 (right half) treat cfg_width_i as half of the panel width. Both use lanes 0 and 1 with W = cfg_width_i / 2. seg_id_o reports 0 and 1 on those lanes in mode 3, and 2 and 3 in mode 4. Lane k's id sits at bits [2k+1:2k].
- R5: Overlap code cfg_ovl_i = c gives c + 1 overlap beats (1 to 8). The first c + 1 beats of segment k + 1 are also valid on lane k. The last used lane gets no overlap.
- R6: seg_first_o[k] marks the beat at position k·W on lane k. On a lane that is not the last used lane, seg_last_o[k] marks its final overlap beat. On the last used lane, it marks the final repetition of the pixel that carried in_eol_i.
- R7: Configuration inputs are captured when the first pixel of a line is accepted. Changes to them during the rest of the line have no effect on that line.
- R8: cfg_err_o is set when a line starts with any of these conditions:
  - a mode code of 5 to 7, which then behaves as mode 0;
  - a width not divisible by the lane count;
  - a multi-lane segment width smaller than the overlap count.

  Once set, cfg_err_o stays high until reset.
- R9: After reset, no lane is valid, in_ready_o is high and cfg_err_o is low.
- R10: At most two lanes are valid at once, and two valid lanes are always adjacent. While a beat is stalled, the lane valids and the pixel value are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_pix_i | input | DW | Input pixel |
| in_valid_i | input | 1 | Input pixel valid |
| in_eol_i | input | 1 | Input pixel is the last of its line |
| in_ready_o | output | 1 | Block accepts an input pixel this cycle |
| cfg_width_i | input | WW | Active width in repeated output beats |
| cfg_mode_i | input | 3 | Segmentation mode code |
| cfg_ovl_i | input | OVW | Overlap beats minus one |
| cfg_rep_i | input | REPW | Extra repetitions per pixel |
| out_ready_i | input | 1 | Downstream accepts the current beat on all lanes |
| seg_valid_o | output | 4 | Per-lane beat valid |
| seg_pix_o | output | DW | Pixel value of the current beat |
| seg_first_o | output | 4 | Per-lane first beat of its segment |
| seg_last_o | output | 4 | Per-lane last beat of its segment |
| seg_id_o | output | 8 | Per-lane segment number, 2 bits per lane |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
The hardest situation to reach is the cycle where a stalled overlap beat sits on two lanes while the next pixel is already waiting at the input. The bench reaches it by running multi-lane lines with repetition enabled while a pseudo-random pattern drops out_ready_i. It then compares every accepted beat's lane mask, markers, ids and pixel against a model computed from the requirements. A second hard case is a configuration change in the middle of a line. The bench applies it on the cycle right after the first pixel is taken, so any failure to capture the configuration at line start shows up in the lane mapping.

// File: rtl/mso_buf_pkg.sv
package mso_buf_pkg;
  typedef enum logic [2:0] {
    MODE_ONE    = 3'd0,
    MODE_TWO    = 3'd1,
    MODE_FOUR   = 3'd2,
    MODE_HALF_L = 3'd3,
    MODE_HALF_R = 3'd4
  } seg_mode_e;

  localparam int unsigned NLANE  = 4;
  localparam int unsigned LANE_W = 2;

  typedef struct packed {
    logic [LANE_W-1:0] shift;      // log2 of lanes in use
    logic [LANE_W-1:0] last_lane;  // index of the last lane in use
    logic [LANE_W-1:0] base;       // id of lane 0
  } seg_geom_t;
endpackage

// File: rtl/mso_cfg_latch.sv
module mso_cfg_latch
  import mso_buf_pkg::*;
#(
  parameter int unsigned WW   = 14,
  parameter int unsigned OVW  = 3,
  parameter int unsigned REPW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WW-1:0]   width_i,
  input  logic [2:0]      mode_i,
  input  logic [OVW-1:0]  ovl_i,
  input  logic [REPW-1:0] rep_i,
  output seg_geom_t       geom_o,
  output logic [WW-1:0]   seg_w_o,
  output logic [OVW:0]    ovl_cnt_o,
  output logic [REPW-1:0] rep_o,
  output logic            err_o
);
  localparam int unsigned OCW = OVW + 1;

  seg_geom_t       geom_n;
  logic            legal;
  logic [WW-1:0]   seg_w_n;
  logic [OCW-1:0]  ovl_n;
  logic            bad;

  always_comb begin
    geom_n = '0;
    legal  = 1'b1;
    case (seg_mode_e'(mode_i))
      MODE_ONE:    ;
      MODE_TWO:    begin geom_n.shift = 2'd1; geom_n.last_lane = 2'd1; end
      MODE_FOUR:   begin geom_n.shift = 2'd2; geom_n.last_lane = 2'd3; end
      MODE_HALF_L: begin geom_n.shift = 2'd1; geom_n.last_lane = 2'd1; end
      MODE_HALF_R: begin geom_n.shift = 2'd1; geom_n.last_lane = 2'd1; geom_n.base = 2'd2; end
      default:     legal = 1'b0;
    endcase
    seg_w_n = width_i >> geom_n.shift;
    ovl_n   = {1'b0, ovl_i} + OCW'(1);
    // last_lane doubles as the remainder mask for a power-of-two lane count
    bad = !legal
        | (|(width_i[1:0] & geom_n.last_lane))
        | ((geom_n.shift != 2'd0) && (seg_w_n < WW'(ovl_n)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geom_o    <= '0;
      seg_w_o   <= '0;
      ovl_cnt_o <= OCW'(1);
      rep_o     <= '0;
      err_o     <= 1'b0;
    end else if (load_i) begin
      geom_o    <= geom_n;
      seg_w_o   <= seg_w_n;
      ovl_cnt_o <= ovl_n;
      rep_o     <= rep_i;
      err_o     <= err_o | bad;
    end
  end
endmodule

// File: rtl/mso_rep_stage.sv
module mso_rep_stage #(
  parameter int unsigned DW   = 24,
  parameter int unsigned REPW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DW-1:0]   in_pix_i,
  input  logic            in_valid_i,
  input  logic            in_eol_i,
  output logic            in_ready_o,
  input  logic [REPW-1:0] rep_i,
  input  logic            out_ready_i,
  output logic            hold_vld_o,
  output logic [DW-1:0]   hold_pix_o,
  output logic            hold_eol_o,
  output logic            fire_o,
  output logic            last_rep_o,
  output logic            line_done_o,
  output logic            load_o
);
  logic [REPW-1:0] rep_cnt;
  logic            line_first;
  logic            beat_done;
  logic            in_fire;

  assign last_rep_o  = (rep_cnt == rep_i);
  assign fire_o      = hold_vld_o & out_ready_i;
  assign beat_done   = fire_o & last_rep_o;
  assign in_ready_o  = !hold_vld_o | beat_done;
  assign in_fire     = in_valid_i & in_ready_o;
  assign line_done_o = beat_done & hold_eol_o;
  // first pixel of a line: after reset, or taken on the edge the previous line ends
  assign load_o      = in_fire & (line_first | line_done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_o <= 1'b0;
      hold_pix_o <= '0;
      hold_eol_o <= 1'b0;
      rep_cnt    <= '0;
      line_first <= 1'b1;
    end else begin
      hold_vld_o <= in_fire | (hold_vld_o & !beat_done);
      if (in_fire) begin
        hold_pix_o <= in_pix_i;
        hold_eol_o <= in_eol_i;
        rep_cnt    <= '0;
      end else if (fire_o) begin
        rep_cnt    <= rep_cnt + REPW'(1);
      end
      if (in_fire)          line_first <= 1'b0;
      else if (line_done_o) line_first <= 1'b1;
    end
  end
endmodule

// File: rtl/mso_seg_map.sv
module mso_seg_map
  import mso_buf_pkg::*;
#(
  parameter int unsigned WW  = 14,
  parameter int unsigned OVW = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             fire_i,
  input  logic                             line_done_i,
  input  logic                             hold_vld_i,
  input  logic                             hold_eol_i,
  input  logic                             last_rep_i,
  input  seg_geom_t                        geom_i,
  input  logic [WW-1:0]                    seg_w_i,
  input  logic [OVW:0]                     ovl_cnt_i,
  output logic [NLANE-1:0]                 valid_o,
  output logic [NLANE-1:0]                 first_o,
  output logic [NLANE-1:0]                 last_o,
  output logic [NLANE-1:0][LANE_W-1:0]     id_o
);
  logic [LANE_W-1:0] seg_cur;
  logic [WW-1:0]     off;
  logic              at_last;
  logic              wrap;
  logic [WW-1:0]     ovl_w;

  assign at_last = (seg_cur == geom_i.last_lane);
  assign wrap    = !at_last && (off == seg_w_i - WW'(1));
  assign ovl_w   = WW'(ovl_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_cur <= '0;
      off     <= '0;
    end else if (fire_i) begin
      if (line_done_i) begin
        seg_cur <= '0;
        off     <= '0;
      end else if (wrap) begin
        seg_cur <= seg_cur + LANE_W'(1);
        off     <= '0;
      end else begin
        off     <= off + WW'(1);
      end
    end
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam logic [LANE_W-1:0] KL = LANE_W'(k);
    logic prim;
    logic ovl;
    logic ovl_end;
    assign prim = hold_vld_i && (seg_cur == KL);
    if (k < NLANE - 1) begin : g_ovl
      assign ovl     = hold_vld_i && (seg_cur == KL + LANE_W'(1)) && (off < ovl_w);
      assign ovl_end = ovl && (off == ovl_w - WW'(1));
    end else begin : g_no_ovl
      assign ovl     = 1'b0;
      assign ovl_end = 1'b0;
    end
    assign valid_o[k] = prim | ovl;
    assign first_o[k] = prim && (off == '0);
    assign last_o[k]  = ovl_end | (prim && at_last && hold_eol_i && last_rep_i);
    assign id_o[k]    = geom_i.base + KL;
  end
endmodule

// File: rtl/mso_pix_seg_buf.sv
module mso_pix_seg_buf
  import mso_buf_pkg::*;
#(
  parameter int unsigned DW   = 24,
  parameter int unsigned WW   = 14,
  parameter int unsigned OVW  = 3,
  parameter int unsigned REPW = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DW-1:0]                in_pix_i,
  input  logic                         in_valid_i,
  input  logic                         in_eol_i,
  output logic                         in_ready_o,
  input  logic [WW-1:0]                cfg_width_i,
  input  logic [2:0]                   cfg_mode_i,
  input  logic [OVW-1:0]               cfg_ovl_i,
  input  logic [REPW-1:0]              cfg_rep_i,
  input  logic                         out_ready_i,
  output logic [NLANE-1:0]             seg_valid_o,
  output logic [DW-1:0]                seg_pix_o,
  output logic [NLANE-1:0]             seg_first_o,
  output logic [NLANE-1:0]             seg_last_o,
  output logic [NLANE-1:0][LANE_W-1:0] seg_id_o,
  output logic                         cfg_err_o
);
  seg_geom_t       geom;
  logic [WW-1:0]   seg_w;
  logic [OVW:0]    ovl_cnt;
  logic [REPW-1:0] rep;
  logic            load;
  logic            hold_vld;
  logic            hold_eol;
  logic            fire;
  logic            last_rep;
  logic            line_done;

  mso_cfg_latch #(.WW(WW), .OVW(OVW), .REPW(REPW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .width_i   (cfg_width_i),
    .mode_i    (cfg_mode_i),
    .ovl_i     (cfg_ovl_i),
    .rep_i     (cfg_rep_i),
    .geom_o    (geom),
    .seg_w_o   (seg_w),
    .ovl_cnt_o (ovl_cnt),
    .rep_o     (rep),
    .err_o     (cfg_err_o)
  );

  mso_rep_stage #(.DW(DW), .REPW(REPW)) u_rep (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_pix_i    (in_pix_i),
    .in_valid_i  (in_valid_i),
    .in_eol_i    (in_eol_i),
    .in_ready_o  (in_ready_o),
    .rep_i       (rep),
    .out_ready_i (out_ready_i),
    .hold_vld_o  (hold_vld),
    .hold_pix_o  (seg_pix_o),
    .hold_eol_o  (hold_eol),
    .fire_o      (fire),
    .last_rep_o  (last_rep),
    .line_done_o (line_done),
    .load_o      (load)
  );

  mso_seg_map #(.WW(WW), .OVW(OVW)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .line_done_i (line_done),
    .hold_vld_i  (hold_vld),
    .hold_eol_i  (hold_eol),
    .last_rep_i  (last_rep),
    .geom_i      (geom),
    .seg_w_i     (seg_w),
    .ovl_cnt_i   (ovl_cnt),
    .valid_o     (seg_valid_o),
    .first_o     (seg_first_o),
    .last_o      (seg_last_o),
    .id_o        (seg_id_o)
  );
endmodule

// File: rtl/mso_pix_seg_buf_chk.sv
module mso_pix_seg_buf_chk
  import mso_buf_pkg::*;
#(
  parameter int unsigned DW = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_ready_o,
  input logic             out_ready_i,
  input logic [NLANE-1:0] seg_valid_o,
  input logic [DW-1:0]    seg_pix_o,
  input logic [NLANE-1:0] seg_first_o,
  input logic [NLANE-1:0] seg_last_o,
  input logic             cfg_err_o
);
  // R10
  max_two_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seg_valid_o) <= 2);

  // R10
  adjacent_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(seg_valid_o) == 2) |-> ((seg_valid_o & (seg_valid_o >> 1)) != '0));

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_valid_o != '0) && !out_ready_i) |=> ($stable(seg_valid_o) && $stable(seg_pix_o)));

  // R2
  stall_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_valid_o != '0) && !out_ready_i) |-> !in_ready_o);

  // R6
  marker_on_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_first_o | seg_last_o) & ~seg_valid_o) == '0);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
endmodule

bind mso_pix_seg_buf mso_pix_seg_buf_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_ready_i (out_ready_i),
  .seg_valid_o (seg_valid_o),
  .seg_pix_o   (seg_pix_o),
  .seg_first_o (seg_first_o),
  .seg_last_o  (seg_last_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/mso_pix_seg_buf_test.sv
`timescale 1ns/1ps
module mso_pix_seg_buf_test;
  localparam int DW = 24;
  localparam int WW = 14;
  localparam int MAXB = 512;

  logic          clk = 0;
  logic          rst_ni = 0;
  logic [DW-1:0] in_pix = '0;
  logic          in_valid = 0;
  logic          in_eol = 0;
  logic          in_ready;
  logic [WW-1:0] cfg_width = '0;
  logic [2:0]    cfg_mode = '0;
  logic [2:0]    cfg_ovl = '0;
  logic [3:0]    cfg_rep = '0;
  logic          out_ready = 1;
  logic [3:0]    seg_valid, seg_first, seg_last;
  logic [DW-1:0] seg_pix;
  logic [7:0]    seg_id;
  logic          cfg_err;

  mso_pix_seg_buf uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_pix_i(in_pix), .in_valid_i(in_valid),
    .in_eol_i(in_eol), .in_ready_o(in_ready), .cfg_width_i(cfg_width),
    .cfg_mode_i(cfg_mode), .cfg_ovl_i(cfg_ovl), .cfg_rep_i(cfg_rep),
    .out_ready_i(out_ready), .seg_valid_o(seg_valid), .seg_pix_o(seg_pix),
    .seg_first_o(seg_first), .seg_last_o(seg_last), .seg_id_o(seg_id),
    .cfg_err_o(cfg_err)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, line_no = 0;
  bit exp_err = 0;
  bit mon_en = 0;
  int nbeats = 0;
  logic [3:0]    obs_mask [MAXB];
  logic [3:0]    obs_first[MAXB];
  logic [3:0]    obs_last [MAXB];
  logic [7:0]    obs_id   [MAXB];
  logic [DW-1:0] obs_pix  [MAXB];
  int            acc_cyc  [MAXB];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 100000) begin
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(negedge clk) if (mon_en && rst_ni && out_ready && seg_valid != 0) begin
    if (nbeats < MAXB) begin
      obs_mask[nbeats]  = seg_valid;
      obs_first[nbeats] = seg_first;
      obs_last[nbeats]  = seg_last;
      obs_id[nbeats]    = seg_id;
      obs_pix[nbeats]   = seg_pix;
    end
    nbeats++;
  end

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pix_of(input int ln, input int i);
    return DW'(ln * 4096 + i);
  endfunction

  task automatic do_reset();
    in_valid = 0; out_ready = 1; rst_ni = 0; exp_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic run_line(input string req, input int mode, input int width,
                          input int ovc, input int rep, input int npix,
                          input bit stall, input bit scramble);
    int sh, base, n, w, ov, total, t;
    bit done, bad;
    logic [15:0] lfsr;
    sh = 0; base = 0;
    case (mode)
      1: sh = 1;
      2: sh = 2;
      3: sh = 1;
      4: begin sh = 1; base = 2; end
      default: sh = 0;
    endcase
    n = 1 << sh; w = width >> sh; ov = ovc + 1; total = npix * (rep + 1);
    bad = (mode > 4) || ((width % n) != 0) || (n > 1 && w < ov);
    if (bad) exp_err = 1;
    line_no++;
    @(posedge clk); #1;
    cfg_mode = 3'(mode); cfg_width = WW'(width); cfg_ovl = 3'(ovc); cfg_rep = 4'(rep);
    nbeats = 0; mon_en = 1; done = 0; lfsr = 16'hACE1;
    fork
      begin
        int i = 0;
        bit acc;
        in_valid = 1; in_pix = pix_of(line_no, 0); in_eol = (npix == 1);
        while (i < npix) begin
          @(negedge clk); acc = in_ready;
          @(posedge clk); #1;
          if (acc) begin
            acc_cyc[i] = cyc;
            i++;
            if (scramble && i == 1) begin
              cfg_mode = 3'd0; cfg_width = WW'(7); cfg_ovl = 3'd0; cfg_rep = 4'd0;
            end
            if (i < npix) begin in_pix = pix_of(line_no, i); in_eol = (i == npix - 1); end
            else begin in_valid = 0; in_eol = 0; end
          end
        end
        t = 0;
        while (nbeats < total && t < 4000) begin @(posedge clk); t++; end
        #1 done = 1;
      end
      begin
        while (!done) begin
          @(posedge clk); #1;
          if (stall) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (!done) out_ready = lfsr[0] | lfsr[3];
          end
        end
      end
    join
    out_ready = 1;
    repeat (2) @(posedge clk);
    mon_en = 0;
    check(req, nbeats == total, "beat count", nbeats, total);
    begin
      bit ok = 1;
      for (int p = 0; p < total && p < MAXB && ok; p++) begin
        int s, off;
        logic [3:0] m, f, l;
        s = p / w; if (s > n - 1) s = n - 1;
        off = p - s * w;
        m = 4'(1 << s); f = (off == 0) ? m : 4'd0; l = 4'd0;
        if (s > 0 && off < ov) begin
          m |= 4'(1 << (s - 1));
          if (off == ov - 1) l |= 4'(1 << (s - 1));
        end
        if (p == total - 1) l |= 4'(1 << (n - 1));
        if (obs_mask[p] !== m) begin ok = 0; check(req, 0, $sformatf("lane mask beat %0d", p), obs_mask[p], m); end
        else if (obs_first[p] !== f) begin ok = 0; check(req, 0, $sformatf("first marker beat %0d", p), obs_first[p], f); end
        else if (obs_last[p] !== l) begin ok = 0; check(req, 0, $sformatf("last marker beat %0d", p), obs_last[p], l); end
        else if (obs_pix[p] !== pix_of(line_no, p / (rep + 1))) begin
          ok = 0; check(req, 0, $sformatf("pixel beat %0d", p), obs_pix[p], pix_of(line_no, p / (rep + 1)));
        end else begin
          for (int k = 0; k < 4; k++)
            if (m[k] && ((obs_id[p] >> (2 * k)) & 8'd3) != 8'(base + k)) begin
              ok = 0; check(req, 0, $sformatf("lane %0d id beat %0d", k, p), (obs_id[p] >> (2 * k)) & 8'd3, base + k);
            end
        end
      end
      if (ok) check(req, 1, "beat content", 0, 0);
    end
    check(req, cfg_err == exp_err, "error flag", cfg_err, exp_err);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R9", seg_valid == 0, "lane valid after reset", seg_valid, 0);
    check("R9", in_ready == 1, "ready after reset", in_ready, 1);
    check("R9", cfg_err == 0, "error after reset", cfg_err, 0);
  endtask

  task automatic t_repeat_rate();
    run_line("R1", 0, 32, 0, 3, 8, 0, 0);
    check("R2", acc_cyc[7] - acc_cyc[0] == 7 * 4, "acceptance spacing",
          acc_cyc[7] - acc_cyc[0], 28);
  endtask

  initial begin
    t_reset();
    run_line("R1", 0, 16, 0, 0, 16, 0, 0);
    t_repeat_rate();
    run_line("R1", 0, 64, 0, 15, 4, 1, 0);
    run_line("R5", 1, 32, 1, 1, 16, 1, 0);
    run_line("R3", 2, 32, 7, 0, 32, 0, 0);
    run_line("R6", 2, 48, 2, 2, 16, 1, 0);
    run_line("R4", 3, 16, 0, 0, 16, 0, 0);
    run_line("R4", 4, 16, 2, 1, 8, 1, 0);
    run_line("R7", 2, 32, 3, 1, 16, 0, 1);
    run_line("R10", 1, 40, 7, 0, 40, 1, 0);
    run_line("R8", 6, 16, 0, 1, 8, 0, 0);
    run_line("R8", 1, 16, 0, 0, 16, 0, 0);
    t_reset();
    run_line("R8", 2, 30, 0, 0, 30, 0, 0);
    t_reset();
    run_line("R8", 2, 16, 5, 0, 16, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule